// File: doc/BRIEF.md
# Dual-Rate Carrier Scheduler With Staggered Conversion Triggers

This block keeps two triangular PWM carriers running from one clock and lines them up so that the conversion triggers of a slow inverter control loop and a fast boost control loop never reach the shared ADC together. The slow carrier is the master. Each time it leaves its zero count it emits a synchronization event. That event reloads the fast carrier with a programmable phase count and restarts the fast carrier's prescaler. The phase count is chosen to cover the sample window plus the first conversion delay.

Each channel produces three kinds of pulse. The first is a start-of-conversion pulse on a selectable carrier extreme. The second is an interrupt request that follows that pulse after a fixed latency. The fast channel skips every other carrier event, which halves its loop rate. The block also drives the boost gate from a compare against the fast carrier. A diagnostic pulse flags any two conversion starts that land within a guard window of each other.

Top module: `dual_rate_pwm_sched`

## Requirements
- R1: The inverter carrier counts 0 up to `inv_half`, then back down to 0, advancing once per `inv_prescale`+1 clocks. Its period is therefore 2·`inv_half`·(`inv_prescale`+1) clocks. `inv_soc` pulses for one clock on each pass through count 0 when `inv_at_peak`=0, or on each pass through count `inv_half` when `inv_at_peak`=1.
- R2: The boost carrier behaves the same way with `boost_half` and `boost_prescale`. `boost_pwm` is high while the boost count is below `boost_cmp`.
- R3: On every clock where the inverter carrier advances from count 0, the boost carrier is loaded with `boost_phase`, counting upward, and its prescaler restarts. With the default values, each `boost_soc` that follows an `inv_soc` comes 2·`boost_half`−`boost_phase`+1 = 571 clocks after it.
- R4: The boost channel forwards only every second selected carrier event (0 when `boost_at_peak`=0, `boost_half` when 1) to `boost_soc`. Both the alternation and any boost event are cleared in a synchronization clock, so the first event after a synchronization always fires. With the default values this gives three boost starts per inverter period.
- R5: `inv_isr` and `boost_isr` each pulse exactly ISR_LAT clocks after the matching start pulse.
- R6: `soc_clash` pulses together with a start pulse when the other channel has issued a start in the same clock or within the last GUARD clocks.
- R7: With `inv_half`=1500, `boost_half`=300, `boost_phase`=30, both prescales 0 and both sources on zero, `soc_clash` never pulses.
- R8: While `rst_n` is low, all outputs are low and both carriers hold count 0, counting upward.
- R9: Prescale values above zero stretch each carrier count by that many extra clocks. The boost prescaler restarts at each synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_half | input | CW | Inverter carrier half-period in counts (at least 1) |
| boost_half | input | CW | Boost carrier half-period in counts (at least 1) |
| boost_phase | input | CW | Count loaded into boost carrier on synchronization (below `boost_half`) |
| boost_cmp | input | CW | Boost gate compare value |
| inv_prescale | input | PW | Extra clocks per inverter count |
| boost_prescale | input | PW | Extra clocks per boost count |
| inv_at_peak | input | 1 | Inverter start source: 0 zero, 1 peak |
| boost_at_peak | input | 1 | Boost start source: 0 zero, 1 peak |
| inv_soc | output | 1 | Inverter start-of-conversion pulse |
| boost_soc | output | 1 | Boost start-of-conversion pulse |
| inv_isr | output | 1 | Inverter interrupt request pulse |
| boost_isr | output | 1 | Boost interrupt request pulse |
| boost_pwm | output | 1 | Boost gate drive |
| soc_clash | output | 1 | Start pulses closer than the guard window |

## Verification
The default carrier set is run over several inverter periods. This shows that the phase offset keeps the two start streams apart, and it measures the exact lag from an inverter start to the next boost start together with the number of boost starts per period. A second pattern moves both start sources to the carrier peaks, which separates the peak decode from the zero decode. A third pattern uses short carriers with unequal prescales, which tests count stretching and the restart of the boost prescaler on synchronization. A fourth pattern sets the phase to zero, so the two starts fall one clock apart and the clash detector must respond.

// File: rtl/dual_rate_pwm_sched.sv
module dual_rate_pwm_sched #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int GUARD = 22,
  parameter int ISR_LAT = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] inv_half,
  input  logic [CW-1:0] boost_half,
  input  logic [CW-1:0] boost_phase,
  input  logic [CW-1:0] boost_cmp,
  input  logic [PW-1:0] inv_prescale,
  input  logic [PW-1:0] boost_prescale,
  input  logic          inv_at_peak,
  input  logic          boost_at_peak,
  output logic          inv_soc,
  output logic          boost_soc,
  output logic          inv_isr,
  output logic          boost_isr,
  output logic          boost_pwm,
  output logic          soc_clash
);
  localparam int GW = $clog2(GUARD + 2);
  localparam logic [GW-1:0] FAR  = GW'(GUARD + 1);
  localparam logic [GW-1:0] NEAR = GW'(GUARD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] inv_cnt, boost_cnt;
  logic          inv_up, boost_up;
  logic [PW-1:0] inv_pre, boost_pre;
  logic          boost_alt;
  logic [GW-1:0] inv_gap, boost_gap;
  logic [ISR_LAT-1:0] inv_pipe, boost_pipe;

  logic inv_tick, boost_tick, sync, inv_ev, boost_ev, inv_soc_c, boost_soc_c, clash_c;

  assign inv_tick    = (inv_pre == inv_prescale);
  assign boost_tick  = (boost_pre == boost_prescale);
  assign sync        = inv_tick && (inv_cnt == '0);
  assign inv_ev      = inv_tick && (inv_at_peak ? (inv_cnt == inv_half) : (inv_cnt == '0));
  assign boost_ev    = boost_tick && !sync &&
                       (boost_at_peak ? (boost_cnt == boost_half) : (boost_cnt == '0));
  assign inv_soc_c   = inv_ev;
  assign boost_soc_c = boost_ev && !boost_alt;
  assign clash_c     = (inv_soc_c && (boost_soc_c || boost_gap <= NEAR)) ||
                       (boost_soc_c && inv_gap <= NEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_cnt <= '0;
      inv_up  <= 1'b1;
      inv_pre <= '0;
    end else begin
      inv_pre <= inv_tick ? '0 : inv_pre + 1'b1;
      if (inv_tick) begin
        if (inv_up) begin
          if (({1'b0, inv_cnt} + 1'b1) >= {1'b0, inv_half}) begin
            inv_cnt <= inv_half;
            inv_up  <= 1'b0;
          end else inv_cnt <= inv_cnt + 1'b1;
        end else begin
          if (inv_cnt <= ONE) begin
            inv_cnt <= '0;
            inv_up  <= 1'b1;
          end else inv_cnt <= inv_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost_cnt <= '0;
      boost_up  <= 1'b1;
      boost_pre <= '0;
      boost_alt <= 1'b0;
    end else if (sync) begin
      boost_cnt <= boost_phase;
      boost_up  <= 1'b1;
      boost_pre <= '0;
      boost_alt <= 1'b0;
    end else begin
      boost_pre <= boost_tick ? '0 : boost_pre + 1'b1;
      if (boost_ev) boost_alt <= ~boost_alt;
      if (boost_tick) begin
        if (boost_up) begin
          if (({1'b0, boost_cnt} + 1'b1) >= {1'b0, boost_half}) begin
            boost_cnt <= boost_half;
            boost_up  <= 1'b0;
          end else boost_cnt <= boost_cnt + 1'b1;
        end else begin
          if (boost_cnt <= ONE) begin
            boost_cnt <= '0;
            boost_up  <= 1'b1;
          end else boost_cnt <= boost_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_gap   <= FAR;
      boost_gap <= FAR;
      inv_soc   <= 1'b0;
      boost_soc <= 1'b0;
      soc_clash <= 1'b0;
      boost_pwm <= 1'b0;
    end else begin
      inv_gap   <= inv_soc_c ? GW'(1) : ((inv_gap == FAR) ? FAR : inv_gap + 1'b1);
      boost_gap <= boost_soc_c ? GW'(1) : ((boost_gap == FAR) ? FAR : boost_gap + 1'b1);
      inv_soc   <= inv_soc_c;
      boost_soc <= boost_soc_c;
      soc_clash <= clash_c;
      boost_pwm <= (boost_cnt < boost_cmp);
    end
  end

  generate
    if (ISR_LAT == 1) begin : g_lat_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          inv_pipe   <= '0;
          boost_pipe <= '0;
        end else begin
          inv_pipe   <= inv_soc;
          boost_pipe <= boost_soc;
        end
      end
    end else begin : g_lat_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          inv_pipe   <= '0;
          boost_pipe <= '0;
        end else begin
          inv_pipe   <= {inv_pipe[ISR_LAT-2:0], inv_soc};
          boost_pipe <= {boost_pipe[ISR_LAT-2:0], boost_soc};
        end
      end
    end
  endgenerate

  assign inv_isr   = inv_pipe[ISR_LAT-1];
  assign boost_isr = boost_pipe[ISR_LAT-1];
endmodule

module dual_rate_pwm_sched_chk #(
  parameter int CW = 16,
  parameter int ISR_LAT = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync,
  input logic [CW-1:0] inv_cnt,
  input logic [CW-1:0] inv_half,
  input logic [CW-1:0] boost_cnt,
  input logic [CW-1:0] boost_phase,
  input logic          boost_alt,
  input logic          inv_soc,
  input logic          boost_soc,
  input logic          inv_isr,
  input logic          boost_isr,
  input logic          soc_clash
);
  int unsigned inv_since, boost_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_since   <= ISR_LAT + 1;
      boost_since <= ISR_LAT + 1;
    end else begin
      inv_since   <= inv_soc ? 1 : ((inv_since > ISR_LAT) ? inv_since : inv_since + 1);
      boost_since <= boost_soc ? 1 : ((boost_since > ISR_LAT) ? boost_since : boost_since + 1);
    end
  end

  // R1
  inv_range_chk: assert property (@(posedge clk) disable iff (!rst_n) inv_cnt <= inv_half);
  // R1
  inv_soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n) inv_soc |=> !inv_soc);
  // R3
  sync_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (boost_cnt == $past(boost_phase)) && !boost_alt);
  // R4
  boost_soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n) boost_soc |=> !boost_soc);
  // R5
  inv_isr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) inv_isr |-> inv_since == ISR_LAT);
  // R5
  boost_isr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) boost_isr |-> boost_since == ISR_LAT);
  // R6
  same_clock_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_soc && boost_soc) |-> soc_clash);
endmodule

bind dual_rate_pwm_sched dual_rate_pwm_sched_chk #(.CW(CW), .ISR_LAT(ISR_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .inv_cnt(inv_cnt), .inv_half(inv_half),
  .boost_cnt(boost_cnt), .boost_phase(boost_phase), .boost_alt(boost_alt),
  .inv_soc(inv_soc), .boost_soc(boost_soc), .inv_isr(inv_isr), .boost_isr(boost_isr),
  .soc_clash(soc_clash)
);

// File: tb/sim_dual_rate_pwm_sched.sv
module sim_dual_rate_pwm_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int GUARD = 22;
  localparam int LAT = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] inv_half = 16'd1500, boost_half = 16'd300, boost_phase = 16'd30, boost_cmp = 16'd150;
  logic [PW-1:0] inv_prescale = '0, boost_prescale = '0;
  logic inv_at_peak = 1'b0, boost_at_peak = 1'b0;
  logic inv_soc, boost_soc, inv_isr, boost_isr, boost_pwm, soc_clash;

  int compared = 0, mismatched = 0;
  bit done = 0;

  dual_rate_pwm_sched #(.CW(CW), .PW(PW), .GUARD(GUARD), .ISR_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .inv_half(inv_half), .boost_half(boost_half),
    .boost_phase(boost_phase), .boost_cmp(boost_cmp), .inv_prescale(inv_prescale),
    .boost_prescale(boost_prescale), .inv_at_peak(inv_at_peak), .boost_at_peak(boost_at_peak),
    .inv_soc(inv_soc), .boost_soc(boost_soc), .inv_isr(inv_isr), .boost_isr(boost_isr),
    .boost_pwm(boost_pwm), .soc_clash(soc_clash));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference
  int c1, c2, p1, p2, g1, g2, n;
  bit up1, up2, skip;
  bit e_isoc, e_bsoc, e_iisr, e_bisr, e_pwm, e_clash;
  int q1[$], q2[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      c1 = 0; c2 = 0; p1 = 0; p2 = 0; up1 = 1; up2 = 1; skip = 0;
      g1 = GUARD + 1; g2 = GUARD + 1; n = 0;
      q1.delete(); q2.delete();
      {e_isoc, e_bsoc, e_iisr, e_bisr, e_pwm, e_clash} = '0;
    end else begin
      bit t1, t2, sy, s1, s2, ev2;
      t1 = (p1 == int'(inv_prescale));
      t2 = (p2 == int'(boost_prescale));
      sy = t1 && c1 == 0;
      s1 = t1 && (inv_at_peak ? c1 == int'(inv_half) : c1 == 0);
      ev2 = t2 && !sy && (boost_at_peak ? c2 == int'(boost_half) : c2 == 0);
      s2 = ev2 && !skip;
      n++;
      e_iisr = (q1.size() > 0 && q1[0] == n);
      if (e_iisr) void'(q1.pop_front());
      e_bisr = (q2.size() > 0 && q2[0] == n);
      if (e_bisr) void'(q2.pop_front());
      e_clash = (s1 && (s2 || g2 <= GUARD)) || (s2 && g1 <= GUARD);
      e_isoc = s1; e_bsoc = s2;
      e_pwm = c2 < int'(boost_cmp);
      if (s1) q1.push_back(n + LAT);
      if (s2) q2.push_back(n + LAT);
      g1 = s1 ? 1 : (g1 > GUARD ? GUARD + 1 : g1 + 1);
      g2 = s2 ? 1 : (g2 > GUARD ? GUARD + 1 : g2 + 1);
      if (t1) begin
        if (up1) begin c1++; if (c1 >= int'(inv_half)) begin c1 = int'(inv_half); up1 = 0; end end
        else begin c1--; if (c1 <= 0) begin c1 = 0; up1 = 1; end end
        p1 = 0;
      end else p1++;
      if (sy) begin
        c2 = int'(boost_phase); up2 = 1; p2 = 0; skip = 0;
      end else begin
        if (ev2) skip = !skip;
        if (t2) begin
          if (up2) begin c2++; if (c2 >= int'(boost_half)) begin c2 = int'(boost_half); up2 = 0; end end
          else begin c2--; if (c2 <= 0) begin c2 = 0; up2 = 1; end end
          p2 = 0;
        end else p2++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitors
  int bn = 0, last_inv = -1, lag = -1, bcount = 0, clashes = 0, per_bad = 0, periods = 0;
  bit pend = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "inv_soc", inv_soc, e_isoc);
      chk("R4", "boost_soc", boost_soc, e_bsoc);
      chk("R5", "inv_isr", inv_isr, e_iisr);
      chk("R5", "boost_isr", boost_isr, e_bisr);
      chk("R2", "boost_pwm", boost_pwm, e_pwm);
      chk("R6", "soc_clash", soc_clash, e_clash);
      bn++;
      if (soc_clash) clashes++;
      if (boost_soc) begin
        bcount++;
        if (pend) begin lag = bn - last_inv; pend = 0; end
      end
      if (inv_soc) begin
        if (last_inv >= 0) begin periods++; if (bcount != 3) per_bad++; end
        last_inv = bn; pend = 1; bcount = 0;
      end
    end
  end

  task automatic run(input int h1, input int h2, input int ph, input int ps1, input int ps2,
                     input bit pk1, input bit pk2, input int cmp, input int cycles);
    @(posedge clk); #1;
    rst_n = 1'b0;
    inv_half = CW'(h1); boost_half = CW'(h2); boost_phase = CW'(ph); boost_cmp = CW'(cmp);
    inv_prescale = PW'(ps1); boost_prescale = PW'(ps2);
    inv_at_peak = pk1; boost_at_peak = pk2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 outputs quiet in reset
    chk("R8", "reset outputs", |{inv_soc, boost_soc, inv_isr, boost_isr, boost_pwm, soc_clash}, 1'b0);
    bn = 0; last_inv = -1; lag = -1; bcount = 0; clashes = 0; per_bad = 0; periods = 0; pend = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 R3 R4 R7 default carriers
    run(1500, 300, 30, 0, 0, 0, 0, 150, 9500);
    chk_int("R3", "boost lag after inverter start", lag, 571);
    chk_int("R4", "periods with wrong boost start count", per_bad, 0);
    chk("R4", "saw whole periods", periods >= 2, 1'b1);
    chk_int("R7", "clash pulses with defaults", clashes, 0);
    // R1 R2 peak sources
    run(1500, 300, 30, 0, 0, 1, 1, 40, 7000);
    chk_int("R7", "clash pulses peak sources", clashes, 0);
    // R9 prescaled short carriers
    run(60, 13, 5, 1, 2, 0, 1, 7, 3000);
    // R6 zero phase forces collision
    run(1500, 300, 0, 0, 0, 0, 0, 150, 4000);
    chk("R6", "clash seen with zero phase", clashes > 0, 1'b1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule